// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block gathers three interrupt sources from a graphics engine into one interrupt line. Two of the sources are one-cycle completion pulses, one for the end of a frame render and one for the end of a binning flush. The block latches each pulse into a pending bit. The third source is the binner's out-of-memory condition. This is a level input, and its status bit follows the input directly. A small register port gives software the status and the enable mask. Software acknowledges an interrupt by writing ones to the status register. It changes the enables by writing ones to a set register or to a clear register.

The block also holds the overflow buffer that software hands to the binner: a base address and a size. Writing the size register produces a one-cycle load strobe toward the binner. When the binner accepts the new memory, it drops its out-of-memory level. The interrupt output is registered. It is the OR, over all sources, of the pending bits that are also enabled.

Register word offsets on `reg_addr`: 0 status, 1 enable-set, 2 enable-clear, 3 overflow base, 4 overflow size. Offsets 5 to 7 read as zero. Source bits: bit 0 frame done, bit 1 flush done, bit 2 out of memory.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the latched pending bits, the enable mask, the overflow base and size, the load strobe and `irq_o` are all zero.
- R2: A pulse on `ev_frame_done_i` sets status bit 0, and a pulse on `ev_flush_done_i` sets status bit 1. The bit is readable after the next clock edge and stays set until it is acknowledged.
- R3: A write to offset 0 clears each latched status bit (bits 0 and 1) whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R5: Status bit 2 always reads the current `oom_i` level. A write of 1 to bit 2 of offset 0 does not clear it while `oom_i` is high.
- R6: A write to offset 1 enables each source whose write-data bit is 1. Zero bits leave the mask unchanged.
- R7: A write to offset 2 disables each source whose write-data bit is 1. Zero bits leave the mask unchanged.
- R8: A read of offset 1 and a read of offset 2 both return the current enable mask in bits 2:0.
- R9: The status register reports pending sources whether or not they are enabled. A pending source that is disabled does not raise `irq_o`.
- R10: `irq_o` is a register. After each clock edge it equals the OR over bits 2:0 of (status AND enable), as those values stood just before that edge.
- R11: Status and enable reads return zero in bits 31:3. Writes to those bits have no effect.
- R12: Offsets 3 and 4 are read/write registers that drive `ovf_base_o` and `ovf_size_o`. A write to offset 4 makes `ovf_load_o` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (3) | Register word offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational) |
| ev_frame_done_i | input | 1 | One-cycle frame-render-done pulse |
| ev_flush_done_i | input | 1 | One-cycle binning-flush-done pulse |
| oom_i | input | 1 | Binner out-of-memory level |
| ovf_base_o | output | DATA_W (32) | Overflow buffer base address |
| ovf_size_o | output | DATA_W (32) | Overflow buffer size |
| ovf_load_o | output | 1 | One-cycle strobe after a size write |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench drives an event and an acknowledge in the same cycle. A design that let the clear win would lose a completion, and status would read zero where one is expected. It acknowledges out-of-memory while the level is still high. A design that latched that bit would read zero, or would keep reading one after the level drops.

It writes all-zero masks to the set and clear registers. A design that copied the write data into the mask would wipe the enables. It also parks a pending source while that source is disabled. This shows that status still reports the source while `irq_o` stays low. Finally, it checks `irq_o` exactly one edge after each change, so a combinational output or one delayed by two cycles shows up as a mismatch.

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_frame_done_i,
  input  logic              ev_flush_done_i,
  input  logic              oom_i,
  output logic [DATA_W-1:0] ovf_base_o,
  output logic [DATA_W-1:0] ovf_size_o,
  output logic              ovf_load_o,
  output logic              irq_o
);
  localparam int NSRC = 3;
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SIZE  = ADDR_W'(4);

  logic [1:0]      latched;
  logic [NSRC-1:0] enable;
  logic [NSRC-1:0] status;
  logic [NSRC-1:0] wbits;
  logic            wr_stat, wr_set, wr_clr;

  assign wbits   = reg_wdata[NSRC-1:0];
  assign wr_stat = reg_we && reg_addr == A_STAT;
  assign wr_set  = reg_we && reg_addr == A_ENSET;
  assign wr_clr  = reg_we && reg_addr == A_ENCLR;
  assign status  = {oom_i, latched};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched    <= '0;
      enable     <= '0;
      irq_o      <= 1'b0;
      ovf_base_o <= '0;
      ovf_size_o <= '0;
      ovf_load_o <= 1'b0;
    end else begin
      latched    <= (latched & ~(wr_stat ? wbits[1:0] : 2'b00))
                    | {ev_flush_done_i, ev_frame_done_i};
      enable     <= (enable | (wr_set ? wbits : '0)) & ~(wr_clr ? wbits : '0);
      irq_o      <= |(status & enable);
      ovf_load_o <= reg_we && reg_addr == A_SIZE;
      if (reg_we && reg_addr == A_BASE) ovf_base_o <= reg_wdata;
      if (reg_we && reg_addr == A_SIZE) ovf_size_o <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:          reg_rdata[NSRC-1:0] = status;
      A_ENSET, A_ENCLR: reg_rdata[NSRC-1:0] = enable;
      A_BASE:          reg_rdata = ovf_base_o;
      A_SIZE:          reg_rdata = ovf_size_o;
      default:         reg_rdata = '0;
    endcase
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done_i |=> latched[0]);
  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[1] && !ev_flush_done_i) |=> !latched[1]);
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbits[0] && ev_frame_done_i) |=> latched[0]);
  assert_enset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((enable & $past(wbits)) == $past(wbits))
               && ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))));
  assert_enclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((enable & $past(wbits)) == '0)
               && ((enable & ~$past(wbits)) == ($past(enable) & ~$past(wbits))));
  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|({oom_i, latched} & enable)));
  assert_load_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_load_o |=> !ovf_load_o || $past(reg_we && reg_addr == A_SIZE));
endmodule

// File: tb/gfx_irq_ctrl_tb_top.sv
module gfx_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_fr = 1'b0, ev_fl = 1'b0, oom = 1'b0;
  logic [31:0] ovf_base, ovf_size;
  logic        ovf_load, irq;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gfx_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_frame_done_i(ev_fr), .ev_flush_done_i(ev_fl), .oom_i(oom),
    .ovf_base_o(ovf_base), .ovf_size_o(ovf_size), .ovf_load_o(ovf_load),
    .irq_o(irq));

  // {addr[2:0], we, wdata[2:0], frame, flush, oom, exp_status[2:0], exp_enable[2:0]}
  localparam logic [15:0] VEC [0:NV-1] = '{
    {3'd1, 1'b1, 3'b001, 3'b000, 3'b000, 3'b001}, // R6 enable frame
    {3'd0, 1'b0, 3'b000, 3'b100, 3'b001, 3'b001}, // R2 frame event
    {3'd0, 1'b0, 3'b000, 3'b000, 3'b001, 3'b001}, // R10 irq rises
    {3'd0, 1'b1, 3'b001, 3'b000, 3'b000, 3'b001}, // R3 ack frame
    {3'd0, 1'b0, 3'b000, 3'b000, 3'b000, 3'b001},
    {3'd0, 1'b0, 3'b000, 3'b010, 3'b010, 3'b001}, // R2 flush event, disabled
    {3'd0, 1'b0, 3'b000, 3'b000, 3'b010, 3'b001}, // R9 no irq
    {3'd1, 1'b1, 3'b010, 3'b000, 3'b010, 3'b011}, // R6
    {3'd0, 1'b0, 3'b000, 3'b000, 3'b010, 3'b011},
    {3'd2, 1'b1, 3'b010, 3'b000, 3'b010, 3'b001}, // R7
    {3'd0, 1'b0, 3'b000, 3'b000, 3'b010, 3'b001},
    {3'd1, 1'b1, 3'b000, 3'b000, 3'b010, 3'b001}, // R6 zeros ignored
    {3'd2, 1'b1, 3'b000, 3'b000, 3'b010, 3'b001}, // R7 zeros ignored
    {3'd0, 1'b1, 3'b010, 3'b010, 3'b010, 3'b001}, // R4 event wins
    {3'd0, 1'b1, 3'b010, 3'b000, 3'b000, 3'b001}, // R3
    {3'd0, 1'b0, 3'b000, 3'b001, 3'b100, 3'b001}, // R5 oom level
    {3'd1, 1'b1, 3'b100, 3'b001, 3'b100, 3'b101},
    {3'd0, 1'b0, 3'b000, 3'b001, 3'b100, 3'b101},
    {3'd0, 1'b1, 3'b100, 3'b001, 3'b100, 3'b101}, // R5 ack does not clear
    {3'd2, 1'b1, 3'b100, 3'b000, 3'b000, 3'b001}, // R5 follows drop
    {3'd0, 1'b1, 3'b111, 3'b100, 3'b001, 3'b001}  // R3 R4 mixed
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cyc(input logic [2:0] a, input logic we, input logic [31:0] d,
                     input logic fr, input logic fl);
    @(negedge clk);
    reg_addr = a; reg_we = we; reg_wdata = d; ev_fr = fr; ev_fl = fl;
    @(posedge clk);
    #1;
    reg_we = 1'b0; ev_fr = 1'b0; ev_fl = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [2:0]  pre_lat, pre_en;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq", {31'b0, irq}, 0);
    rd(3'd0, d); check("R1 status", d, 0);
    rd(3'd1, d); check("R1 enable", d, 0);
    check("R1 base", ovf_base, 0);
    check("R1 load", {31'b0, ovf_load}, 0);
    @(negedge clk); rst_n = 1'b1;

    pre_lat = '0; pre_en = '0;
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      logic exp_irq;
      v = VEC[i];
      oom = v[6];
      exp_irq = |({v[6], pre_lat[1:0]} & pre_en);
      cyc(v[15:13], v[12], {29'b0, v[11:9]}, v[8], v[7]);
      rd(3'd0, d); check($sformatf("R2/R3/R4/R5/R9 status vec%0d", i), d, {29'b0, v[5:3]});
      rd(3'd1, d); check($sformatf("R6/R8 enset read vec%0d", i), d, {29'b0, v[2:0]});
      rd(3'd2, d); check($sformatf("R7/R8 enclr read vec%0d", i), d, {29'b0, v[2:0]});
      check($sformatf("R10 irq vec%0d", i), {31'b0, irq}, {31'b0, exp_irq});
      pre_lat = v[5:3]; pre_en = v[2:0];
    end

    cyc(3'd1, 1'b1, 32'hFFFF_FFF8, 1'b0, 1'b0);
    rd(3'd1, d); check("R11 enable upper bits", d, 32'h1);
    cyc(3'd0, 1'b1, 32'hFFFF_FFF8, 1'b0, 1'b0);
    rd(3'd0, d); check("R11 status upper bits", d, 32'h1);

    cyc(3'd3, 1'b1, 32'h1234_5678, 1'b0, 1'b0);
    check("R12 no load on base write", {31'b0, ovf_load}, 0);
    cyc(3'd4, 1'b1, 32'h0004_0000, 1'b0, 1'b0);
    check("R12 load pulse", {31'b0, ovf_load}, 1);
    check("R12 size out", ovf_size, 32'h0004_0000);
    rd(3'd3, d); check("R12 base read", d, 32'h1234_5678);
    rd(3'd4, d); check("R12 size read", d, 32'h0004_0000);
    cyc(3'd0, 1'b0, 0, 1'b0, 1'b0);
    check("R12 load single cycle", {31'b0, ovf_load}, 0);

    cyc(3'd0, 1'b0, 0, 1'b0, 1'b0);
    check("R10 irq pending enabled", {31'b0, irq}, 1);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 irq after reset", {31'b0, irq}, 0);
    rd(3'd0, d); check("R1 status after reset", d, 0);
    rd(3'd2, d); check("R1 enable after reset", d, 0);
    check("R1 size after reset", ovf_size, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule